// File: doc/BRIEF.md
# Pipeline Execute Stage

This block is the execute stage of a 32-bit, five-stage load/store pipeline. Each cycle it takes the fields the decode stage has already pulled out of an instruction: a major opcode, a function code, a shift amount, two register operands, a sign-extended immediate, the next program counter and a destination register number. It computes one registered result word, a registered control-transfer target and a registered taken flag. It also passes the destination register number on to the memory stage one cycle later.

Each of the two operands goes through a forwarding selector before it reaches the arithmetic. There are three choices: the block's own previous result, for a dependency one instruction back; the value of the memory stage, for a dependency two instructions back; or the register file value. The stage covers register-register logic and shifts, signed compare, immediate arithmetic and logic, upper-immediate loads, load/store address generation, register-indirect jumps, absolute jumps with and without a link value, and conditional branches on equality. Multiply, divide and the register file are outside the block.

Top module: `exec_stage`

## Requirements
- R1: While `rst_i` is high at a rising edge, every output is zero in the following cycle: `res_o`, `tgt_o`, `taken_o` and `dest_o`.
- R2: With `op_i` = 0x00, function code 0x00 shifts operand B left by `shamt_i`. Code 0x02 shifts B right logically. Code 0x03 shifts B right arithmetically.
- R3: With `op_i` = 0x00, function codes 0x24, 0x25, 0x26 and 0x27 give A AND B, A OR B, A XOR B and NOT(A OR B). Code 0x2A gives 1 when A < B as signed numbers and 0 otherwise.
- R4: With `op_i` = 0x00 and function code 0x08, `taken_o` is 1, `tgt_o` equals operand A and `res_o` is 0.
- R5: Opcodes 0x02 and 0x03 always set `taken_o`. Their target is PC[31:28], then imm[25:0], then two zero bits. Opcode 0x03 returns PC + 8 in `res_o`. Opcode 0x02 returns 0.
- R6: Opcode 0x04 is taken when A equals B. Opcode 0x05 is taken when A differs from B. A taken branch targets PC + 4 + (imm << 2). Both return 0 in `res_o`.
- R7: Opcode 0x08 returns A + imm. Opcode 0x0A returns the signed compare A < imm as 1 or 0. Opcodes 0x0C, 0x0D and 0x0E return A AND imm, A OR imm and A XOR imm.
- R8: Opcode 0x0F returns imm[15:0] in the upper half of `res_o`, with the lower half zero.
- R9: Opcodes 0x23 and 0x2B return A + imm as the memory address.
- R10: Each operand picks its source with a fixed priority. The execute-forward select comes first and gives the current `res_o`. The memory-forward select comes next and gives `mem_val_i`. Otherwise the register value is used.
- R11: All outputs are registered. `dest_o` equals `dest_i` from the previous cycle, and `res_o`, `tgt_o` and `taken_o` reflect the inputs of the previous cycle.
- R12: An unrecognised opcode, or an unrecognised function code under opcode 0x00, gives `res_o` = 0 and `taken_o` = 0. Whenever `taken_o` is 0, `tgt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Major opcode |
| fn_i | input | 6 | Function code, used with opcode 0x00 |
| shamt_i | input | 5 | Shift amount |
| rs_val_i | input | 32 | Register file value for operand A |
| rt_val_i | input | 32 | Register file value for operand B |
| imm_i | input | 32 | Sign-extended immediate |
| pc_i | input | 32 | Next program counter |
| dest_i | input | 5 | Destination register number |
| fwd_ex_a_i | input | 1 | Operand A takes the previous result |
| fwd_ex_b_i | input | 1 | Operand B takes the previous result |
| fwd_mem_a_i | input | 1 | Operand A takes the memory-stage value |
| fwd_mem_b_i | input | 1 | Operand B takes the memory-stage value |
| mem_val_i | input | 32 | Memory-stage value for forwarding |
| res_o | output | 32 | Registered result |
| tgt_o | output | 32 | Registered control-transfer target |
| taken_o | output | 1 | Registered taken flag |
| dest_o | output | 5 | Destination register, one cycle delayed |

## Verification
Random stimulus mixes every defined opcode and function code with arbitrary codes. This shows whether the decoder tells implemented operations apart from unrecognised ones. Operands are random words with random forwarding selects, so the choice between register, previous-result and memory-stage sources is tested together with every operation.

Directed cases cover the ends of the operand and shift ranges:
- equal and unequal operands for both branches;
- negative against positive values for the signed compares;
- shifts of 0 and 31 on a word with the top bit set, which separates the logical right shift from the arithmetic one;
- both forwarding selects raised at once, which shows the priority order.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OP_W-1:0] OPC_JLNK = 6'h03;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_XORI = 6'h0E;
  localparam logic [OP_W-1:0] OPC_UPPR = 6'h0F;
  localparam logic [OP_W-1:0] OPC_LDW  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STW  = 6'h2B;

  localparam logic [FN_W-1:0] FNC_SHL  = 6'h00;
  localparam logic [FN_W-1:0] FNC_SHR  = 6'h02;
  localparam logic [FN_W-1:0] FNC_SHRA = 6'h03;
  localparam logic [FN_W-1:0] FNC_JREG = 6'h08;
  localparam logic [FN_W-1:0] FNC_AND  = 6'h24;
  localparam logic [FN_W-1:0] FNC_OR   = 6'h25;
  localparam logic [FN_W-1:0] FNC_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FNC_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FNC_SLT  = 6'h2A;

  typedef enum logic [3:0] {
    ALU_ZERO,
    ALU_SHL,
    ALU_SHR,
    ALU_SHRA,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOR,
    ALU_SLT,
    ALU_ADD,
    ALU_UPPR,
    ALU_LINK
  } alu_fn_e;

  typedef enum logic [2:0] {
    XFER_NONE,
    XFER_REG,
    XFER_ABS,
    XFER_EQ,
    XFER_NE
  } xfer_e;

  typedef struct packed {
    alu_fn_e alu;
    logic    b_is_imm;
    xfer_e   xfer;
  } dec_t;

endpackage

// File: rtl/exec_fwd_mux.sv
module exec_fwd_mux #(
  parameter int XLEN = 32
) (
  input  logic            sel_ex_i,
  input  logic            sel_mem_i,
  input  logic [XLEN-1:0] reg_val_i,
  input  logic [XLEN-1:0] ex_val_i,
  input  logic [XLEN-1:0] mem_val_i,
  output logic [XLEN-1:0] opnd_o
);

  // The younger producer wins: the execute result is one instruction back.
  always_comb begin
    if (sel_ex_i) begin
      opnd_o = ex_val_i;
    end else if (sel_mem_i) begin
      opnd_o = mem_val_i;
    end else begin
      opnd_o = reg_val_i;
    end
  end

endmodule

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output dec_t            dec_o
);

  always_comb begin
    dec_o.alu      = ALU_ZERO;
    dec_o.b_is_imm = 1'b0;
    dec_o.xfer     = XFER_NONE;
    unique case (op_i)
      OPC_REG: begin
        unique case (fn_i)
          FNC_SHL:  dec_o.alu  = ALU_SHL;
          FNC_SHR:  dec_o.alu  = ALU_SHR;
          FNC_SHRA: dec_o.alu  = ALU_SHRA;
          FNC_JREG: dec_o.xfer = XFER_REG;
          FNC_AND:  dec_o.alu  = ALU_AND;
          FNC_OR:   dec_o.alu  = ALU_OR;
          FNC_XOR:  dec_o.alu  = ALU_XOR;
          FNC_NOR:  dec_o.alu  = ALU_NOR;
          FNC_SLT:  dec_o.alu  = ALU_SLT;
          default:  dec_o.alu  = ALU_ZERO;
        endcase
      end
      OPC_JMP:  dec_o.xfer = XFER_ABS;
      OPC_JLNK: begin
        dec_o.xfer = XFER_ABS;
        dec_o.alu  = ALU_LINK;
      end
      OPC_BEQ:  dec_o.xfer = XFER_EQ;
      OPC_BNE:  dec_o.xfer = XFER_NE;
      OPC_ADDI, OPC_LDW, OPC_STW: begin
        dec_o.alu      = ALU_ADD;
        dec_o.b_is_imm = 1'b1;
      end
      OPC_SLTI: begin
        dec_o.alu      = ALU_SLT;
        dec_o.b_is_imm = 1'b1;
      end
      OPC_ANDI: begin
        dec_o.alu      = ALU_AND;
        dec_o.b_is_imm = 1'b1;
      end
      OPC_ORI: begin
        dec_o.alu      = ALU_OR;
        dec_o.b_is_imm = 1'b1;
      end
      OPC_XORI: begin
        dec_o.alu      = ALU_XOR;
        dec_o.b_is_imm = 1'b1;
      end
      OPC_UPPR: begin
        dec_o.alu      = ALU_UPPR;
        dec_o.b_is_imm = 1'b1;
      end
      default: begin
        dec_o.alu  = ALU_ZERO;
        dec_o.xfer = XFER_NONE;
      end
    endcase
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHAMT_W = $clog2(XLEN)
) (
  input  alu_fn_e            fn_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [XLEN-1:0]    pc_i,
  output logic [XLEN-1:0]    res_o
);

  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LINK_OFS = XLEN'(8);

  logic lt_signed;

  assign lt_signed = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (fn_i)
      ALU_SHL:  res_o = b_i << shamt_i;
      ALU_SHR:  res_o = b_i >> shamt_i;
      ALU_SHRA: res_o = $unsigned($signed(b_i) >>> shamt_i);
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_NOR:  res_o = ~(a_i | b_i);
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_signed};
      ALU_ADD:  res_o = a_i + b_i;
      ALU_UPPR: res_o = {b_i[HALF-1:0], {HALF{1'b0}}};
      ALU_LINK: res_o = pc_i + LINK_OFS;
      default:  res_o = '0;
    endcase
  end

endmodule

// File: rtl/exec_xfer.sv
module exec_xfer
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  xfer_e           kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            taken_o,
  output logic [XLEN-1:0] tgt_o
);

  localparam int REGION_W = 4;
  localparam int FIELD_W  = XLEN - REGION_W - 2;
  localparam logic [XLEN-1:0] SEQ_OFS = XLEN'(4);

  logic            same;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;
  logic [XLEN-1:0] raw_tgt;

  assign same    = (a_i == b_i);
  assign rel_tgt = pc_i + SEQ_OFS + (imm_i << 2);
  assign abs_tgt = {pc_i[XLEN-1 -: REGION_W], imm_i[FIELD_W-1:0], 2'b00};

  always_comb begin
    taken_o = 1'b0;
    raw_tgt = '0;
    unique case (kind_i)
      XFER_REG: begin
        taken_o = 1'b1;
        raw_tgt = a_i;
      end
      XFER_ABS: begin
        taken_o = 1'b1;
        raw_tgt = abs_tgt;
      end
      XFER_EQ: begin
        taken_o = same;
        raw_tgt = rel_tgt;
      end
      XFER_NE: begin
        taken_o = !same;
        raw_tgt = rel_tgt;
      end
      default: begin
        taken_o = 1'b0;
        raw_tgt = '0;
      end
    endcase
  end

  assign tgt_o = taken_o ? raw_tgt : '0;

endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_AW  = 5,
  parameter int SHAMT_W = $clog2(XLEN)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [FN_W-1:0]    fn_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [REG_AW-1:0]  dest_i,
  input  logic               fwd_ex_a_i,
  input  logic               fwd_ex_b_i,
  input  logic               fwd_mem_a_i,
  input  logic               fwd_mem_b_i,
  input  logic [XLEN-1:0]    mem_val_i,
  output logic [XLEN-1:0]    res_o,
  output logic [XLEN-1:0]    tgt_o,
  output logic               taken_o,
  output logic [REG_AW-1:0]  dest_o
);

  localparam int NOPND = 2;

  logic [NOPND-1:0]           sel_ex;
  logic [NOPND-1:0]           sel_mem;
  logic [NOPND-1:0][XLEN-1:0] reg_val;
  logic [NOPND-1:0][XLEN-1:0] opnd;

  dec_t            dec;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] xfer_tgt;
  logic            xfer_taken;

  assign sel_ex  = {fwd_ex_b_i,  fwd_ex_a_i};
  assign sel_mem = {fwd_mem_b_i, fwd_mem_a_i};
  assign reg_val = {rt_val_i,    rs_val_i};

  for (genvar g = 0; g < NOPND; g++) begin : g_fwd
    exec_fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel_ex_i  (sel_ex[g]),
      .sel_mem_i (sel_mem[g]),
      .reg_val_i (reg_val[g]),
      .ex_val_i  (res_o),
      .mem_val_i (mem_val_i),
      .opnd_o    (opnd[g])
    );
  end

  exec_decode u_dec (
    .op_i  (op_i),
    .fn_i  (fn_i),
    .dec_o (dec)
  );

  assign alu_b = dec.b_is_imm ? imm_i : opnd[1];

  exec_alu #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_alu (
    .fn_i    (dec.alu),
    .a_i     (opnd[0]),
    .b_i     (alu_b),
    .shamt_i (shamt_i),
    .pc_i    (pc_i),
    .res_o   (alu_res)
  );

  exec_xfer #(.XLEN(XLEN)) u_xfer (
    .kind_i  (dec.xfer),
    .a_i     (opnd[0]),
    .b_i     (opnd[1]),
    .imm_i   (imm_i),
    .pc_i    (pc_i),
    .taken_o (xfer_taken),
    .tgt_o   (xfer_tgt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o   <= '0;
      tgt_o   <= '0;
      taken_o <= 1'b0;
      dest_o  <= '0;
    end else begin
      res_o   <= alu_res;
      tgt_o   <= xfer_tgt;
      taken_o <= xfer_taken;
      dest_o  <= dest_i;
    end
  end

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
  import exec_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [OP_W-1:0]   op_i,
  input logic [FN_W-1:0]   fn_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [REG_AW-1:0] dest_i,
  input logic              fwd_ex_a_i,
  input logic              fwd_mem_a_i,
  input logic [XLEN-1:0]   res_o,
  input logic [XLEN-1:0]   tgt_o,
  input logic              taken_o,
  input logic [REG_AW-1:0] dest_o
);

  localparam int HALF = XLEN / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (res_o == '0 && tgt_o == '0 && !taken_o && dest_o == '0)); // R1

  AST_DEST_DELAY: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> dest_o == $past(dest_i)); // R11

  AST_IDLE_TARGET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !taken_o |-> tgt_o == '0); // R12

  AST_JUMP_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OPC_JMP || op_i == OPC_JLNK) |=> taken_o); // R5

  AST_LINK_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OPC_JLNK) |=> res_o == $past(pc_i) + XLEN'(8)); // R5

  AST_JREG_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OPC_REG && fn_i == FNC_JREG && !fwd_ex_a_i && !fwd_mem_a_i)
      |=> (taken_o && tgt_o == $past(rs_val_i))); // R4

  AST_UPPER_LOW_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == OPC_UPPR) |=> res_o[HALF-1:0] == '0); // R8

endmodule

bind exec_stage exec_stage_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .op_i        (op_i),
  .fn_i        (fn_i),
  .rs_val_i    (rs_val_i),
  .pc_i        (pc_i),
  .dest_i      (dest_i),
  .fwd_ex_a_i  (fwd_ex_a_i),
  .fwd_mem_a_i (fwd_mem_a_i),
  .res_o       (res_o),
  .tgt_o       (tgt_o),
  .taken_o     (taken_o),
  .dest_o      (dest_o)
);

// File: tb/exec_stage_tb.sv
`timescale 1ns/1ps
module exec_stage_tb;

  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic [5:0]  op_i = '0;
  logic [5:0]  fn_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] imm_i = '0;
  logic [31:0] pc_i = '0;
  logic [4:0]  dest_i = '0;
  logic        fwd_ex_a_i = 1'b0;
  logic        fwd_ex_b_i = 1'b0;
  logic        fwd_mem_a_i = 1'b0;
  logic        fwd_mem_b_i = 1'b0;
  logic [31:0] mem_val_i = '0;
  logic [31:0] res_o;
  logic [31:0] tgt_o;
  logic        taken_o;
  logic [4:0]  dest_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] prev_res = '0;
  logic        done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  exec_stage u_dut (
    .clk_i(clk_i), .rst_i(rst_i), .op_i(op_i), .fn_i(fn_i), .shamt_i(shamt_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .imm_i(imm_i), .pc_i(pc_i),
    .dest_i(dest_i), .fwd_ex_a_i(fwd_ex_a_i), .fwd_ex_b_i(fwd_ex_b_i),
    .fwd_mem_a_i(fwd_mem_a_i), .fwd_mem_b_i(fwd_mem_b_i), .mem_val_i(mem_val_i),
    .res_o(res_o), .tgt_o(tgt_o), .taken_o(taken_o), .dest_o(dest_o)
  );

  // Reference model from the requirements: returns {taken, target, result}
  function automatic logic [64:0] model(input logic [5:0] op, input logic [5:0] fn,
      input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] imm, input logic [31:0] pc);
    logic [31:0] r; logic [31:0] t; logic k;
    r = 0; t = 0; k = 0;
    case (op)
      6'h00: case (fn)
        6'h00: r = b << sh;                                  // R2
        6'h02: r = b >> sh;
        6'h03: r = $unsigned($signed(b) >>> sh);
        6'h08: begin k = 1; t = a; end                       // R4
        6'h24: r = a & b;                                    // R3
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h27: r = ~(a | b);
        6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: ;
      endcase
      6'h02: begin k = 1; t = {pc[31:28], imm[25:0], 2'b00}; end              // R5
      6'h03: begin k = 1; t = {pc[31:28], imm[25:0], 2'b00}; r = pc + 32'd8; end
      6'h04: begin k = (a == b); t = pc + 32'd4 + (imm << 2); end              // R6
      6'h05: begin k = (a != b); t = pc + 32'd4 + (imm << 2); end
      6'h08: r = a + imm;                                                      // R7
      6'h0A: r = ($signed(a) < $signed(imm)) ? 32'd1 : 32'd0;
      6'h0C: r = a & imm;
      6'h0D: r = a | imm;
      6'h0E: r = a ^ imm;
      6'h0F: r = {imm[15:0], 16'h0};                                           // R8
      6'h23, 6'h2B: r = a + imm;                                               // R9
      default: ;                                                               // R12
    endcase
    if (!k) t = 0;
    return {k, t, r};
  endfunction

  function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: case (fn)
        6'h00, 6'h02, 6'h03: return "R2";
        6'h08: return "R4";
        6'h24, 6'h25, 6'h26, 6'h27, 6'h2A: return "R3";
        default: return "R12";
      endcase
      6'h02, 6'h03: return "R5";
      6'h04, 6'h05: return "R6";
      6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: return "R7";
      6'h0F: return "R8";
      6'h23, 6'h2B: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
      input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one instruction at a falling edge, check after the next rising edge.
  task automatic issue(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
      input logic [31:0] rs, input logic [31:0] rt, input logic [31:0] imm,
      input logic [31:0] pc, input logic [3:0] fwd, input logic [31:0] memv,
      input logic [4:0] dst, input string req_fwd);
    logic [31:0] a; logic [31:0] b; logic [64:0] e; string rq;
    op_i = op; fn_i = fn; shamt_i = sh; rs_val_i = rs; rt_val_i = rt; imm_i = imm;
    pc_i = pc; {fwd_ex_b_i, fwd_ex_a_i, fwd_mem_b_i, fwd_mem_a_i} = fwd;
    mem_val_i = memv; dest_i = dst;
    a = fwd[2] ? prev_res : (fwd[0] ? memv : rs);   // R10
    b = fwd[3] ? prev_res : (fwd[1] ? memv : rt);
    e = model(op, fn, sh, a, b, imm, pc);
    rq = (req_fwd != "") ? req_fwd : req_of(op, fn);
    @(posedge clk_i); @(negedge clk_i);
    check(rq, "result", res_o, e[31:0]);
    check(rq, "target", tgt_o, e[63:32]);
    check(rq, "taken", {31'd0, taken_o}, {31'd0, e[64]});
    check("R11", "dest", {27'd0, dest_o}, {27'd0, dst});
    prev_res = e[31:0];
  endtask

  function automatic logic [5:0] pick_op();
    case ($urandom % 16)
      0: return 6'h02;  1: return 6'h03;  2: return 6'h04;  3: return 6'h05;
      4: return 6'h08;  5: return 6'h0A;  6: return 6'h0C;  7: return 6'h0D;
      8: return 6'h0E;  9: return 6'h0F;  10: return 6'h23; 11: return 6'h2B;
      12: return 6'($urandom);
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [5:0] pick_fn();
    case ($urandom % 11)
      0: return 6'h00; 1: return 6'h02; 2: return 6'h03; 3: return 6'h08;
      4: return 6'h24; 5: return 6'h25; 6: return 6'h26; 7: return 6'h27;
      8: return 6'h2A; 9: return 6'($urandom);
      default: return 6'h01;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state with busy inputs
    op_i = 6'h03; pc_i = 32'h1234_5678; dest_i = 5'd9; imm_i = 32'h55;
    repeat (3) @(negedge clk_i);
    check("R1", "result", res_o, 32'h0);
    check("R1", "target", tgt_o, 32'h0);
    check("R1", "taken", {31'd0, taken_o}, 32'h0);
    check("R1", "dest", {27'd0, dest_o}, 32'h0);
    rst_i = 1'b0;
    prev_res = 0;

    // Directed corner cases
    issue(6'h00, 6'h00, 5'd1, 0, 32'h10, 0, 0, 4'b0, 0, 5'd1, "");          // R2
    issue(6'h00, 6'h00, 5'd31, 0, 32'h3, 0, 0, 4'b0, 0, 5'd2, "");
    issue(6'h00, 6'h02, 5'd31, 0, 32'h8000_0000, 0, 0, 4'b0, 0, 5'd3, "");
    issue(6'h00, 6'h03, 5'd31, 0, 32'h8000_0000, 0, 0, 4'b0, 0, 5'd4, "");
    issue(6'h00, 6'h03, 5'd0, 0, 32'h8000_0001, 0, 0, 4'b0, 0, 5'd5, "");
    issue(6'h00, 6'h27, 5'd0, 32'h0111_1111, 32'h1, 0, 0, 4'b0, 0, 5'd6, ""); // R3
    issue(6'h00, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 4'b0, 0, 5'd7, "");
    issue(6'h00, 6'h2A, 5'd0, 32'h1, 32'hFFFF_FFFF, 0, 0, 4'b0, 0, 5'd8, "");
    issue(6'h00, 6'h08, 5'd0, 32'h11, 0, 0, 0, 4'b0, 0, 5'd9, "");           // R4
    issue(6'h02, 0, 0, 0, 0, 32'h1000, 32'h1000_0011, 4'b0, 0, 5'd10, "");   // R5
    issue(6'h03, 0, 0, 0, 0, 32'h1000, 32'h1000_0011, 4'b0, 0, 5'd31, "");
    issue(6'h04, 0, 0, 32'h0111_1111, 32'h1, 32'h1000, 32'h1000_0011, 4'b0, 0, 5'd0, ""); // R6
    issue(6'h04, 0, 0, 32'h1, 32'h1, 32'h0010_1000, 32'h1000_0011, 4'b0, 0, 5'd1, "");
    issue(6'h05, 0, 0, 32'h5, 32'h5, 32'hFFFF_FFFF, 32'h100, 4'b0, 0, 5'd2, "");
    issue(6'h05, 0, 0, 32'h5, 32'h6, 32'hFFFF_FFFE, 32'h100, 4'b0, 0, 5'd3, "");
    issue(6'h0A, 0, 0, 32'h8000_0000, 0, 32'h0, 0, 4'b0, 0, 5'd4, "");       // R7
    issue(6'h0F, 0, 0, 0, 0, 32'hABCD_1234, 0, 4'b0, 0, 5'd5, "");           // R8
    issue(6'h23, 0, 0, 32'h11, 0, 32'h0100_1000, 0, 4'b0, 0, 5'd6, "");      // R9
    issue(6'h3F, 6'h2A, 0, 32'h7, 32'h9, 32'h1, 32'h44, 4'b0, 0, 5'd7, "");  // R12
    issue(6'h00, 6'h3F, 0, 32'h7, 32'h9, 32'h1, 32'h44, 4'b0, 0, 5'd8, "");
    // R10: forwarding priority with both selects raised
    issue(6'h08, 0, 0, 32'h0, 0, 32'h1234, 0, 4'b0, 0, 5'd9, "R10");
    issue(6'h00, 6'h25, 0, 32'hDEAD, 32'h0, 0, 0, 4'b0101, 32'hF000_0000, 5'd10, "R10");
    issue(6'h00, 6'h25, 0, 32'hDEAD, 32'h0, 0, 0, 4'b0001, 32'h0F00_0000, 5'd11, "R10");
    issue(6'h00, 6'h26, 0, 32'h1, 32'h2, 0, 0, 4'b1010, 32'h0000_00F0, 5'd12, "R10");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op;
      logic [5:0] fn;
      logic [31:0] ra;
      logic [31:0] rb;
      op = pick_op();
      fn = pick_fn();
      ra = $urandom;
      rb = ($urandom % 4 == 0) ? ra : $urandom;
      issue(op, fn, 5'($urandom), ra, rb, $urandom, $urandom, 4'($urandom),
            $urandom, 5'($urandom), "");
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule